// File: doc/BRIEF.md
# Dual-Lane Packed Multiply-Accumulate Unit

This functional unit treats each of two 32-bit source words as a pair of signed 16-bit halves. It multiplies the matching halves and adds each of the two products into its own 40-bit running sum. One sum is fed by the low halves and the other by the high halves. A command is taken into a first pipeline stage on the clock edge where it is presented. The two sums are read and updated in the second stage, on the following edge. A new command may be issued on every cycle.

Software reaches the sums through a side port that has a selector. The selector chooses one sum for both reading and writing. The low word of the chosen sum (bits 31:0) and its top byte (bits 39:32) can be written on their own. The read port shows the chosen sum with all accepted commands already counted. It returns the low word directly and the top byte sign-extended to 32 bits. These paths are used to set up, save and restore the sums around a context switch. Instruction decode, saturation and rounding are handled elsewhere.

Top module: `pmac_unit`

## Requirements
- R1: A synchronous active-high reset clears both 40-bit sums to zero, so that `rd_lo` and `rd_hi` read 0 for either selector value.
- R2: Sum 0 (selected with `acc_sel`=0) adds the signed product of `src_a[15:0]` and `src_b[15:0]`.
- R3: Sum 1 (selected with `acc_sel`=1) adds the signed product of `src_a[31:16]` and `src_b[31:16]`.
- R4: Each 32-bit product is sign-extended to 40 bits before it is added, and the sum wraps modulo 2^40.
- R5: A command accepted on a clock edge (`mac_valid`=1) is already contained in the read port value from that edge onward, and is counted exactly once.
- R6: Commands issued on consecutive cycles are each accumulated exactly once, and none is lost.
- R7: With `lo_we`=1, bits 31:0 of the selected sum take `wr_data` and bits 39:32 are kept. With `hi_we`=1, bits 39:32 take `wr_data[7:0]` and bits 31:0 are kept. Both may be given together. The other sum is not changed.
- R8: `rd_hi` returns bits 39:32 of the selected sum, sign-extended to 32 bits from bit 39.
- R9: A write request in the cycle right after an accepted command, while that command is updating the sums in stage 2, is ignored. The accumulate takes priority.
- R10: With `mac_valid`=0 and no write request, both sums hold their value whatever the operand inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mac_valid | input | 1 | Issue a multiply-accumulate command this cycle |
| src_a | input | 32 | First source word, two signed 16-bit halves |
| src_b | input | 32 | Second source word, two signed 16-bit halves |
| acc_sel | input | 1 | Selects the sum for reading and writing |
| lo_we | input | 1 | Write bits 31:0 of the selected sum |
| hi_we | input | 1 | Write bits 39:32 of the selected sum |
| wr_data | input | 32 | Write data; bits 7:0 are used for the top byte |
| rd_lo | output | 32 | Bits 31:0 of the selected sum, pending command included |
| rd_hi | output | 32 | Bits 39:32 of the selected sum, sign-extended |

## Verification
Two functions can land in the same cycle: the stage-2 accumulate and a software write to a sum. The bench provokes this by raising `lo_we` or `hi_we` in the cycle right after a command is accepted, and also in the same cycle as a new command. In the first case the write must disappear. In the second the write must land and the command must then add on top of it. A behavioural model with the same priority is compared against the read port on every clock, so a lost or doubled update shows up in the next sample.

// File: rtl/pmac_pkg.sv
package pmac_pkg;

    localparam int LANE_W = 16;
    localparam int LANES  = 2;
    localparam int ACC_W  = 40;
    localparam int LO_W   = 32;
    localparam int HI_W   = ACC_W - LO_W;
    localparam int SRC_W  = LANES * LANE_W;

    // Software write request toward one accumulator.
    typedef struct packed {
        logic            lo_we;
        logic            hi_we;
        logic [LO_W-1:0] data;
    } acc_wr_t;

    // Operand pair held in stage 1.
    typedef struct packed {
        logic             valid;
        logic [SRC_W-1:0] a;
        logic [SRC_W-1:0] b;
    } stage1_t;

    // Signed lane product, sign-extended to accumulator width.
    function automatic logic [ACC_W-1:0] lane_product(
        input logic [LANE_W-1:0] x,
        input logic [LANE_W-1:0] y
    );
        logic signed [2*LANE_W-1:0] p;
        logic signed [ACC_W-1:0]    e;
        p = $signed(x) * $signed(y);
        e = p;
        return e;
    endfunction

endpackage

// File: rtl/pmac_stage1.sv
module pmac_stage1
    import pmac_pkg::*;
#(
    parameter int W = SRC_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    input  logic [W-1:0] in_a,
    input  logic [W-1:0] in_b,
    output logic         s1_valid,
    output logic [W-1:0] s1_a,
    output logic [W-1:0] s1_b
);

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_valid <= 1'b0;
            s1_a     <= '0;
            s1_b     <= '0;
        end else begin
            s1_valid <= in_valid;
            if (in_valid) begin
                s1_a <= in_a;
                s1_b <= in_b;
            end
        end
    end

    AST_CAPTURE_ONCE: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> s1_valid); // R6

    AST_NO_PHANTOM: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !s1_valid); // R10

endmodule

// File: rtl/pmac_lane.sv
module pmac_lane
    import pmac_pkg::*;
#(
    parameter int LW = LANE_W,
    parameter int AW = ACC_W,
    parameter int LOW = LO_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          s2_valid,
    input  logic [LW-1:0] op_a,
    input  logic [LW-1:0] op_b,
    input  acc_wr_t       wr,
    output logic [AW-1:0] view
);

    localparam int HW = AW - LOW;

    logic [AW-1:0] acc_q;
    logic [AW-1:0] prod;

    assign prod = lane_product(op_a, op_b);

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
        end else if (s2_valid) begin
            acc_q <= acc_q + prod;
        end else begin
            if (wr.lo_we) acc_q[LOW-1:0]  <= wr.data;
            if (wr.hi_we) acc_q[AW-1:LOW] <= wr.data[HW-1:0];
        end
    end

    // Read view counts the operation currently in stage 2.
    assign view = acc_q + (s2_valid ? prod : '0);

    AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (acc_q == '0)); // R1

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!s2_valid && !wr.lo_we && !wr.hi_we) |=> $stable(acc_q)); // R10

    AST_TOP_KEPT: assert property (@(posedge clk) disable iff (rst)
        (!s2_valid && wr.lo_we && !wr.hi_we) |=> $stable(acc_q[AW-1:LOW])); // R7

    AST_LOW_KEPT: assert property (@(posedge clk) disable iff (rst)
        (!s2_valid && !wr.lo_we && wr.hi_we) |=> $stable(acc_q[LOW-1:0])); // R7

endmodule

// File: rtl/pmac_unit.sv
module pmac_unit
    import pmac_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             mac_valid,
    input  logic [SRC_W-1:0] src_a,
    input  logic [SRC_W-1:0] src_b,
    input  logic             acc_sel,
    input  logic             lo_we,
    input  logic             hi_we,
    input  logic [LO_W-1:0]  wr_data,
    output logic [LO_W-1:0]  rd_lo,
    output logic [LO_W-1:0]  rd_hi
);

    localparam int SEL_W = (LANES > 1) ? $clog2(LANES) : 1;

    stage1_t       s1;
    logic [ACC_W-1:0] views [LANES];
    logic [ACC_W-1:0] rd_view;

    pmac_stage1 #(.W(SRC_W)) u_stage1 (
        .clk      (clk),
        .rst      (rst),
        .in_valid (mac_valid),
        .in_a     (src_a),
        .in_b     (src_b),
        .s1_valid (s1.valid),
        .s1_a     (s1.a),
        .s1_b     (s1.b)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        acc_wr_t lane_wr;
        logic    hit;

        assign hit           = (SEL_W'(acc_sel) == SEL_W'(g));
        assign lane_wr.lo_we = lo_we && hit;
        assign lane_wr.hi_we = hi_we && hit;
        assign lane_wr.data  = wr_data;

        pmac_lane #(.LW(LANE_W), .AW(ACC_W), .LOW(LO_W)) u_lane (
            .clk      (clk),
            .rst      (rst),
            .s2_valid (s1.valid),
            .op_a     (s1.a[g*LANE_W +: LANE_W]),
            .op_b     (s1.b[g*LANE_W +: LANE_W]),
            .wr       (lane_wr),
            .view     (views[g])
        );
    end

    assign rd_view = views[acc_sel];
    assign rd_lo   = rd_view[LO_W-1:0];
    assign rd_hi   = {{(LO_W-HI_W){rd_view[ACC_W-1]}}, rd_view[ACC_W-1:LO_W]};

    AST_WRITE_YIELDS: assert property (@(posedge clk) disable iff (rst)
        (s1.valid && (lo_we || hi_we) && !mac_valid)
            |=> (rd_view == $past(rd_view)) || $changed(acc_sel)); // R9

endmodule

// File: tb/tb_pmac_unit.sv
module tb_pmac_unit;

    logic        clk = 1'b0;
    logic        rst;
    logic        mac_valid;
    logic [31:0] src_a, src_b;
    logic        acc_sel;
    logic        lo_we, hi_we;
    logic [31:0] wr_data;
    logic [31:0] rd_lo, rd_hi;

    int total = 0;
    int bad = 0;
    bit finished = 0;
    string tag = "R1";

    always #5 clk = ~clk;

    pmac_unit dut (
        .clk(clk), .rst(rst), .mac_valid(mac_valid),
        .src_a(src_a), .src_b(src_b), .acc_sel(acc_sel),
        .lo_we(lo_we), .hi_we(hi_we), .wr_data(wr_data),
        .rd_lo(rd_lo), .rd_hi(rd_hi)
    );

    // Behavioural reference
    logic [39:0] m_acc  [2];
    logic [39:0] m_prod [2];
    logic        m_pend;
    logic [31:0] rng = 32'h1234_5678;

    function automatic logic [39:0] ref_prod(logic [15:0] x, logic [15:0] y);
        longint p;
        p = longint'($signed(x)) * longint'($signed(y));
        return p[39:0];
    endfunction

    function automatic logic [31:0] next_rand(logic [31:0] s);
        logic [31:0] v;
        v = s ^ (s << 13);
        v = v ^ (v >> 17);
        v = v ^ (v << 5);
        return v;
    endfunction

    task automatic model_edge();
        if (rst) begin
            m_acc[0] = '0; m_acc[1] = '0; m_pend = 1'b0;
        end else begin
            if (m_pend) begin
                m_acc[0] = m_acc[0] + m_prod[0];
                m_acc[1] = m_acc[1] + m_prod[1];
            end else begin
                if (lo_we) m_acc[acc_sel][31:0]  = wr_data;
                if (hi_we) m_acc[acc_sel][39:32] = wr_data[7:0];
            end
            m_pend    = mac_valid;
            m_prod[0] = ref_prod(src_a[15:0],  src_b[15:0]);
            m_prod[1] = ref_prod(src_a[31:16], src_b[31:16]);
        end
    endtask

    task automatic compare();
        logic [39:0] e;
        logic [31:0] elo, ehi;
        e   = m_acc[acc_sel] + (m_pend ? m_prod[acc_sel] : 40'd0);
        elo = e[31:0];
        ehi = {{24{e[39]}}, e[39:32]};
        total++;
        if (rd_lo !== elo || rd_hi !== ehi) begin
            bad++;
            $display("FAIL %s sel=%0d rd_hi/rd_lo actual=%h_%h expected=%h_%h",
                     tag, acc_sel, rd_hi, rd_lo, ehi, elo);
        end
    endtask

    task automatic cycle();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        if (!rst) compare();
    endtask

    task automatic idle_inputs();
        mac_valid = 0; lo_we = 0; hi_we = 0;
    endtask

    task automatic mac(logic [31:0] a, logic [31:0] b);
        mac_valid = 1; src_a = a; src_b = b;
        cycle();
        mac_valid = 0;
    endtask

    task automatic write(logic s, logic lo, logic hi, logic [31:0] d);
        acc_sel = s; lo_we = lo; hi_we = hi; wr_data = d;
        cycle();
        lo_we = 0; hi_we = 0;
    endtask

    task automatic look(logic s);
        acc_sel = s;
        cycle();
    endtask

    initial begin
        rst = 1; idle_inputs(); src_a = 0; src_b = 0; acc_sel = 0; wr_data = 0;
        m_acc[0] = 0; m_acc[1] = 0; m_prod[0] = 0; m_prod[1] = 0; m_pend = 0;
        @(negedge clk);
        repeat (3) cycle();
        rst = 0;
        tag = "R1"; look(0); look(1);

        tag = "R2"; mac(32'h0000_0003, 32'h0000_0005); look(0); look(1);
        tag = "R3"; acc_sel = 1; mac(32'h0007_0000, 32'h0009_0000); look(1); look(0);

        tag = "R5"; acc_sel = 0; mac(32'h0002_0004, 32'h0003_0006);
        look(0); look(1);

        tag = "R4"; mac(32'h0000_8000, 32'h0000_7FFF); look(0);
        mac(32'h8000_FFFF, 32'h8000_0001); look(1);
        write(0, 1, 1, 32'hFFFF_FF7F); look(0);
        mac(32'h0000_0001, 32'h0000_0001); look(0);
        write(0, 1, 1, 32'hFFFF_FFFF);
        mac(32'h0000_0001, 32'h0000_0001); look(0);

        tag = "R8"; write(1, 0, 1, 32'h0000_00C3); look(1);
        write(1, 0, 1, 32'h0000_0042); look(1);

        tag = "R7"; write(0, 1, 0, 32'hDEAD_BEEF); look(0); look(1);
        write(1, 0, 1, 32'h0000_00A5); look(1); look(0);
        write(1, 1, 1, 32'h0BAD_F00D); look(1); look(0);

        tag = "R6";
        for (int i = 0; i < 40; i++) begin
            rng = next_rand(rng); src_a = rng;
            rng = next_rand(rng); src_b = rng;
            acc_sel = rng[3];
            mac_valid = 1;
            cycle();
        end
        mac_valid = 0; look(0); look(1);

        tag = "R9";
        mac(32'h0011_0022, 32'h0033_0044);
        write(0, 1, 1, 32'h5555_5555); look(0);
        acc_sel = 1; mac(32'h0100_0100, 32'h0100_0100);
        write(1, 1, 0, 32'h7777_7777); look(1);
        mac_valid = 1; src_a = 32'h0002_0002; src_b = 32'h0003_0003;
        acc_sel = 0; lo_we = 1; wr_data = 32'h0000_1000;
        cycle();
        idle_inputs(); look(0); look(1);

        tag = "R10";
        for (int i = 0; i < 10; i++) begin
            rng = next_rand(rng); src_a = rng; src_b = ~rng;
            acc_sel = rng[0];
            cycle();
        end

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog expired in %s", tag);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule